// File: doc/BRIEF.md
# Evaluation-Stack State Save/Restore Engine

This block moves the state of a suspended computation between an eight-entry evaluation stack (with its context registers) and a block of memory. It is used when switching processes. A save writes the frame pointer, the stack-pointer word and the live part of the stack into the block. A dump does the same, also stores the source link, and afterwards clears the stack pointer. A load brings the two link registers and the stack-pointer word back, splits that word into a depth and a pending breakpoint byte, and refills the live stack entries.

The block is driven by a one-cycle command that carries an operation code and a block base address. It reads stack entries through a register-file read port and writes them back through a write port. Context registers are written through a single selectable port. Memory is reached through a master port that moves one word per cycle, with read data returned in the same cycle. Words always move from the highest block offset to the lowest.

Top module: `ssr_engine`

## Requirements
- R1: Out of reset, busy, done, mem_req, ctx_we and stk_wr_en are low and brk_byte is zero.
- R2: A save (cmd_op 2'b00) writes lp_in to base+9, then sp_in to base+8, then stack entries from the highest live index down to entry 0, where entry k goes to base+k and is read through stk_rd_idx=k.
- R3: On save, with depth being sp_in[3:0], a depth of 0 to 5 writes entries 0 to depth+1, and a depth of 6 or more (up to 15) writes all eight entries.
- R4: A dump (cmd_op 2'b01) first writes src_in to base+10, then behaves as a save, then spends one extra cycle writing zero to the stack-pointer register (ctx_sel 2'd2) with mem_req low.
- R5: A load (cmd_op 2'b10) reads base+10 into the source-link register (ctx_sel 2'd0), base+9 into the destination-link register (ctx_sel 2'd1), and base+8 into the stack-pointer register (ctx_sel 2'd2) as its bits [3:0] zero-extended.
- R6: On load, brk_byte takes bits [15:8] of the word at base+8 and holds it until the next load, so a zero high byte gives zero.
- R7: On load, with depth being bits [3:0] of word 8, a depth above 6 reloads all eight entries and otherwise entries 0 to depth+1, entry k taken from base+k and written through stk_wr_idx=k.
- R8: One word moves per cycle at strictly descending offsets with no idle cycle between words, and mem_we is high only for save and dump.
- R9: done is a one-cycle pulse in the cycle after the final action, busy falls with it, and a command presented while busy is ignored.
- R10: cmd_op 2'b11 is ignored: no memory, register or done activity follows and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | 00 save, 01 dump, 10 load, 11 ignored |
| cmd_base | input | AW | Base address of the state block |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| lp_in | input | DW | Current frame (local) pointer |
| sp_in | input | DW | Current stack-pointer word |
| src_in | input | DW | Current source link |
| stk_rd_idx | output | 3 | Stack register-file read index |
| stk_rd_data | input | DW | Stack register-file read data |
| stk_wr_en | output | 1 | Stack register-file write enable |
| stk_wr_idx | output | 3 | Stack register-file write index |
| stk_wr_data | output | DW | Stack register-file write data |
| ctx_we | output | 1 | Context register write enable |
| ctx_sel | output | 2 | 0 source link, 1 destination link, 2 stack pointer |
| ctx_wdata | output | DW | Context register write data |
| brk_byte | output | 8 | Breakpoint byte from the last load |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, same cycle |

## Verification
The bench builds the engine with its defaults: 16-bit words and addresses, eight stack entries and a 4-bit depth field. A 4-bit depth reaches values 9 to 15 beyond the stack size, so the saturation of both the save and load counts is exercised. The boundary depths 0, 5, 6 and 7 also fall inside that range, where the two count rules meet. The sixteen address bits leave room for several disjoint blocks in the bench memory, so save, dump and load round trips can be run without overlap.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [1:0] {
    OP_SAVE = 2'd0,
    OP_DUMP = 2'd1,
    OP_LOAD = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CTX_SRC = 2'd0,
    CTX_DST = 2'd1,
    CTX_SP  = 2'd2
  } ctx_e;
endpackage

// File: rtl/ssr_unpack.sv
module ssr_unpack #(
  parameter int NSTK  = 8,
  parameter int DEP_W = 4,
  parameter int OFF_W = 4
) (
  input  logic [DEP_W-1:0] depth,
  output logic [OFF_W-1:0] top_idx
);
  // highest live entry: depth+1, clamped at the last stack slot
  function automatic logic [OFF_W-1:0] top_of(input logic [DEP_W-1:0] d);
    if (d >= DEP_W'(NSTK - 1)) return OFF_W'(NSTK - 1);
    return OFF_W'(d + 1'b1);
  endfunction

  assign top_idx = top_of(depth);
endmodule

// File: rtl/ssr_seq.sv
module ssr_seq
  import ssr_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NSTK  = 8,
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  op_e              cmd_op,
  input  logic [AW-1:0]    cmd_base,
  input  logic [OFF_W-1:0] save_top,
  input  logic [OFF_W-1:0] load_top,
  output logic             busy,
  output logic             done,
  output logic             xfer,
  output logic             zap,
  output op_e              op_q,
  output logic [AW-1:0]    base_q,
  output logic [OFF_W-1:0] off
);
  localparam int SP_OFF  = NSTK;
  localparam int DST_OFF = NSTK + 1;
  localparam int SRC_OFF = NSTK + 2;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_ZAP} st_e;

  st_e              st;
  logic [OFF_W-1:0] top_q;
  logic             accept;

  assign accept = cmd_valid && (st == S_IDLE) && (cmd_op != OP_NONE);
  assign busy   = (st != S_IDLE);
  assign xfer   = (st == S_XFER);
  assign zap    = (st == S_ZAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      off    <= '0;
      top_q  <= '0;
      op_q   <= OP_SAVE;
      base_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          st     <= S_XFER;
          op_q   <= cmd_op;
          base_q <= cmd_base;
          top_q  <= save_top;
          off    <= (cmd_op == OP_SAVE) ? OFF_W'(DST_OFF) : OFF_W'(SRC_OFF);
        end
        S_XFER: begin
          if (off == OFF_W'(SP_OFF)) begin
            off <= (op_q == OP_LOAD) ? load_top : top_q;
          end else if (off == '0) begin
            if (op_q == OP_DUMP) st <= S_ZAP;
            else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end else begin
            off <= off - 1'b1;
          end
        end
        S_ZAP: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_OFF_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && $past(xfer)) |-> (off < $past(off))); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(base_q))); // R9
endmodule

// File: rtl/ssr_route.sv
module ssr_route
  import ssr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int NSTK  = 8,
  parameter int DEP_W = 4,
  parameter int OFF_W = 4,
  parameter int IDX_W = 3
) (
  input  op_e              op_q,
  input  logic             xfer,
  input  logic             zap,
  input  logic [OFF_W-1:0] off,
  input  logic [AW-1:0]    base_q,
  input  logic [DW-1:0]    lp_in,
  input  logic [DW-1:0]    sp_in,
  input  logic [DW-1:0]    src_in,
  input  logic [DW-1:0]    stk_rd_data,
  input  logic [DW-1:0]    mem_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             ctx_we,
  output ctx_e             ctx_sel,
  output logic [DW-1:0]    ctx_wdata,
  output logic [IDX_W-1:0] stk_rd_idx,
  output logic             stk_wr_en,
  output logic [IDX_W-1:0] stk_wr_idx,
  output logic [DW-1:0]    stk_wr_data,
  output logic             brk_capture
);
  localparam int SP_OFF  = NSTK;
  localparam int DST_OFF = NSTK + 1;
  localparam int SRC_OFF = NSTK + 2;

  logic is_load, on_stack, on_sp, on_dst, on_src;

  assign is_load  = (op_q == OP_LOAD);
  assign on_stack = (off < OFF_W'(NSTK));
  assign on_sp    = (off == OFF_W'(SP_OFF));
  assign on_dst   = (off == OFF_W'(DST_OFF));
  assign on_src   = (off == OFF_W'(SRC_OFF));

  // word stored at the current offset during save or dump
  function automatic logic [DW-1:0] save_word(input logic s, input logic d, input logic p,
                                              input logic [DW-1:0] src, input logic [DW-1:0] lp,
                                              input logic [DW-1:0] sp, input logic [DW-1:0] stk);
    if (s) return src;
    if (d) return lp;
    if (p) return sp;
    return stk;
  endfunction

  assign mem_req   = xfer;
  assign mem_we    = xfer && !is_load;
  assign mem_addr  = base_q + AW'(off);
  assign mem_wdata = save_word(on_src, on_dst, on_sp, src_in, lp_in, sp_in, stk_rd_data);

  assign stk_rd_idx  = off[IDX_W-1:0];
  assign stk_wr_en   = xfer && is_load && on_stack;
  assign stk_wr_idx  = off[IDX_W-1:0];
  assign stk_wr_data = mem_rdata;

  assign ctx_we      = (xfer && is_load && !on_stack) || zap;
  assign ctx_sel     = zap ? CTX_SP : (on_src ? CTX_SRC : (on_dst ? CTX_DST : CTX_SP));
  assign ctx_wdata   = zap ? '0 : (on_sp ? DW'(mem_rdata[DEP_W-1:0]) : mem_rdata);
  assign brk_capture = xfer && is_load && on_sp;
endmodule

// File: rtl/ssr_engine.sv
module ssr_engine
  import ssr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int NSTK  = 8,
  parameter int DEP_W = 4,
  parameter int BRK_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [AW-1:0]            cmd_base,
  output logic                     busy,
  output logic                     done,
  input  logic [DW-1:0]            lp_in,
  input  logic [DW-1:0]            sp_in,
  input  logic [DW-1:0]            src_in,
  output logic [$clog2(NSTK)-1:0]  stk_rd_idx,
  input  logic [DW-1:0]            stk_rd_data,
  output logic                     stk_wr_en,
  output logic [$clog2(NSTK)-1:0]  stk_wr_idx,
  output logic [DW-1:0]            stk_wr_data,
  output logic                     ctx_we,
  output logic [1:0]               ctx_sel,
  output logic [DW-1:0]            ctx_wdata,
  output logic [BRK_W-1:0]         brk_byte,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_wdata,
  input  logic [DW-1:0]            mem_rdata
);
  localparam int IDX_W = $clog2(NSTK);
  localparam int OFF_W = $clog2(NSTK + 3);

  op_e              op_w;
  ctx_e             ctx_sel_e;
  logic             xfer_w, zap_w, brk_cap;
  logic [AW-1:0]    base_w;
  logic [OFF_W-1:0] off_w, save_top, load_top;

  ssr_unpack #(.NSTK(NSTK), .DEP_W(DEP_W), .OFF_W(OFF_W)) u_save_cnt (
    .depth(sp_in[DEP_W-1:0]), .top_idx(save_top));

  ssr_unpack #(.NSTK(NSTK), .DEP_W(DEP_W), .OFF_W(OFF_W)) u_load_cnt (
    .depth(mem_rdata[DEP_W-1:0]), .top_idx(load_top));

  ssr_seq #(.AW(AW), .NSTK(NSTK), .OFF_W(OFF_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op_e'(cmd_op)),
    .cmd_base(cmd_base), .save_top(save_top), .load_top(load_top),
    .busy(busy), .done(done), .xfer(xfer_w), .zap(zap_w),
    .op_q(op_w), .base_q(base_w), .off(off_w));

  ssr_route #(.DW(DW), .AW(AW), .NSTK(NSTK), .DEP_W(DEP_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_route (
    .op_q(op_w), .xfer(xfer_w), .zap(zap_w), .off(off_w), .base_q(base_w),
    .lp_in(lp_in), .sp_in(sp_in), .src_in(src_in), .stk_rd_data(stk_rd_data),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .ctx_we(ctx_we), .ctx_sel(ctx_sel_e), .ctx_wdata(ctx_wdata),
    .stk_rd_idx(stk_rd_idx), .stk_wr_en(stk_wr_en), .stk_wr_idx(stk_wr_idx),
    .stk_wr_data(stk_wr_data), .brk_capture(brk_cap));

  assign ctx_sel = ctx_sel_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       brk_byte <= '0;
    else if (brk_cap) brk_byte <= mem_rdata[DW-1:DW-BRK_W];
  end

  AST_LOAD_READS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_w && op_w == OP_LOAD) |-> !mem_we); // R8

  AST_ZAP_CLEARS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_we && !mem_req) |-> (ctx_sel == 2'd2 && ctx_wdata == '0)); // R4

  AST_BRK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_cap |=> $stable(brk_byte)); // R6

  AST_SP_DEPTH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_we && mem_req && ctx_sel == 2'd2) |-> ((ctx_wdata >> DEP_W) == '0)); // R5

  AST_STK_WR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    stk_wr_en |-> (mem_req && !mem_we)); // R7
endmodule

// File: tb/sim_ssr_engine.sv
module sim_ssr_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_base = '0;
  logic        busy, done;
  logic [15:0] lp_in = '0, sp_in = '0, src_in = '0;
  logic [2:0]  stk_rd_idx, stk_wr_idx;
  logic [15:0] stk_rd_data, stk_wr_data;
  logic        stk_wr_en, ctx_we, mem_req, mem_we;
  logic [1:0]  ctx_sel;
  logic [15:0] ctx_wdata, mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  brk_byte;

  always #2 clk = ~clk;

  ssr_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_base(cmd_base),
    .busy(busy), .done(done), .lp_in(lp_in), .sp_in(sp_in), .src_in(src_in),
    .stk_rd_idx(stk_rd_idx), .stk_rd_data(stk_rd_data), .stk_wr_en(stk_wr_en),
    .stk_wr_idx(stk_wr_idx), .stk_wr_data(stk_wr_data), .ctx_we(ctx_we), .ctx_sel(ctx_sel),
    .ctx_wdata(ctx_wdata), .brk_byte(brk_byte), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [15:0] mem [0:255];
  logic [15:0] rf  [0:7];
  assign mem_rdata   = mem[mem_addr[7:0]];
  assign stk_rd_data = rf[stk_rd_idx];
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (stk_wr_en) rf[stk_wr_idx] <= stk_wr_data;
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic mreq; logic mwe; logic [15:0] addr; logic [15:0] wdata;
    logic cwe; logic [1:0] csel; logic [15:0] cdata;
    logic swe; logic [2:0] sidx; logic [15:0] sdata;
    logic dn; string req;
  } item_t;
  item_t q[$];
  item_t it;

  function automatic item_t mk(logic mreq, logic mwe, logic [15:0] a, logic [15:0] wd,
                               logic cwe, logic [1:0] cs, logic [15:0] cd,
                               logic swe, logic [2:0] si, logic [15:0] sd, logic dn, string r);
    item_t x;
    x.mreq = mreq; x.mwe = mwe; x.addr = a; x.wdata = wd; x.cwe = cwe; x.csel = cs;
    x.cdata = cd; x.swe = swe; x.sidx = si; x.sdata = sd; x.dn = dn; x.req = r;
    return x;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: every active cycle must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished && (mem_req || ctx_we || stk_wr_en || done)) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R9/R10 unexpected activity actual=req%b we%b a%h ctx%b stk%b dn%b expected=idle",
                 mem_req, mem_we, mem_addr, ctx_we, stk_wr_en, done);
      end else begin
        bit ok;
        it = q.pop_front();
        ok = (mem_req == it.mreq) && (mem_we == it.mwe) && (done == it.dn) &&
             (ctx_we == it.cwe) && (stk_wr_en == it.swe);
        if (it.mreq) ok = ok && (mem_addr == it.addr);
        if (it.mwe)  ok = ok && (mem_wdata == it.wdata);
        if (it.cwe)  ok = ok && (ctx_sel == it.csel) && (ctx_wdata == it.cdata);
        if (it.swe)  ok = ok && (stk_wr_idx == it.sidx) && (stk_wr_data == it.sdata);
        if (!ok) begin
          errors++;
          $display("FAIL %s actual=req%b we%b a%h wd%h ctx%b/%0d/%h stk%b/%0d/%h dn%b expected=req%b we%b a%h wd%h ctx%b/%0d/%h stk%b/%0d/%h dn%b",
                   it.req, mem_req, mem_we, mem_addr, mem_wdata, ctx_we, ctx_sel, ctx_wdata,
                   stk_wr_en, stk_wr_idx, stk_wr_data, done, it.mreq, it.mwe, it.addr, it.wdata,
                   it.cwe, it.csel, it.cdata, it.swe, it.sidx, it.sdata, it.dn);
        end
      end
    end
  end

  task automatic issue(logic [1:0] op, logic [15:0] base);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_base = base;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain(string req);
    int n = 0;
    while (q.size() != 0 && n < 100) begin
      @(posedge clk);
      n++;
    end
    chk(q.size() == 0, req, "scoreboard drained", q.size(), 0);
    q.delete();
    @(negedge clk);
    chk(busy == 1'b0, req, "busy after done", busy, 0);
    @(negedge clk);
  endtask

  // save (R2, R3) or dump (R4)
  task automatic do_save(bit dump, logic [15:0] base, logic [15:0] lp, logic [15:0] sp,
                         logic [15:0] src, string req);
    int d = sp & 16'hF;
    int n = (d > 5) ? 8 : d + 2;
    lp_in = lp; sp_in = sp; src_in = src;
    if (dump) q.push_back(mk(1, 1, base + 16'd10, src, 0, 0, 0, 0, 0, 0, 0, {req, " src word"}));
    q.push_back(mk(1, 1, base + 16'd9, lp, 0, 0, 0, 0, 0, 0, 0, {req, " lp word"}));
    q.push_back(mk(1, 1, base + 16'd8, sp, 0, 0, 0, 0, 0, 0, 0, {req, " sp word"}));
    for (int k = n - 1; k >= 0; k--)
      q.push_back(mk(1, 1, base + 16'(k), rf[k], 0, 0, 0, 0, 0, 0, 0, {req, " stack word"}));
    if (dump) q.push_back(mk(0, 0, 0, 0, 1, 2'd2, 16'd0, 0, 0, 0, 0, "R4 sp cleared"));
    q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 done pulse"));
    issue(dump ? 2'd1 : 2'd0, base);
  endtask

  // load (R5, R7), then breakpoint byte (R6)
  task automatic do_load(logic [15:0] base, string req);
    logic [15:0] w8 = mem[base[7:0] + 8'd8];
    int d = w8 & 16'hF;
    int n = (d > 6) ? 8 : d + 2;
    q.push_back(mk(1, 0, base + 16'd10, 0, 1, 2'd0, mem[base[7:0] + 8'd10], 0, 0, 0, 0, "R5 source link"));
    q.push_back(mk(1, 0, base + 16'd9, 0, 1, 2'd1, mem[base[7:0] + 8'd9], 0, 0, 0, 0, "R5 dest link"));
    q.push_back(mk(1, 0, base + 16'd8, 0, 1, 2'd2, {12'd0, w8[3:0]}, 0, 0, 0, 0, "R5 stack pointer"));
    for (int k = n - 1; k >= 0; k--)
      q.push_back(mk(1, 0, base + 16'(k), 0, 0, 0, 0, 1, 3'(k), mem[base[7:0] + 8'(k)], 0, {req, " entry"}));
    q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 done pulse"));
    issue(2'd2, base);
    drain(req);
    chk(brk_byte == w8[15:8], "R6", "breakpoint byte", brk_byte, w8[15:8]);
  endtask

  task automatic set_block(logic [15:0] base, logic [15:0] w8);
    for (int k = 0; k < 11; k++) mem[base[7:0] + 8'(k)] = 16'h7000 + base + 16'(k * 17);
    mem[base[7:0] + 8'd8] = w8;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3 + 16'h100);
    for (int i = 0; i < 8; i++) rf[i] = 16'hA000 + 16'(i * 11);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1", "busy in reset", busy, 0);
    chk(done == 0, "R1", "done in reset", done, 0);
    chk(mem_req == 0 && ctx_we == 0 && stk_wr_en == 0, "R1", "strobes in reset",
        {mem_req, ctx_we, stk_wr_en}, 0);
    chk(brk_byte == 0, "R1", "brk in reset", brk_byte, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_save(0, 16'd16,  16'h1111, 16'h0000, 16'h0, "R3 save depth 0"); drain("R2");
    do_save(0, 16'd32,  16'h2222, 16'h0003, 16'h0, "R3 save depth 3"); drain("R2");
    do_save(0, 16'd48,  16'h3333, 16'h0005, 16'h0, "R3 save depth 5"); drain("R3");
    do_save(0, 16'd64,  16'h4444, 16'h0006, 16'h0, "R3 save depth 6"); drain("R3");
    do_save(0, 16'd80,  16'h5555, 16'hAB0C, 16'h0, "R3 save depth 12"); drain("R3");
    do_save(1, 16'd96,  16'h6666, 16'h0002, 16'hBEEF, "R4 dump depth 2"); drain("R4");

    // round trip: scramble stack, reload the dumped block (R7)
    for (int i = 0; i < 8; i++) rf[i] = 16'h0F00 + 16'(i);
    do_load(16'd96, "R7 load depth 2");

    set_block(16'd112, 16'h3A04); do_load(16'd112, "R7 load depth 4");
    set_block(16'd128, 16'h0007); do_load(16'd128, "R7 load depth 7");
    set_block(16'd144, 16'hC50F); do_load(16'd144, "R7 load depth 15");
    set_block(16'd160, 16'h0006); do_load(16'd160, "R7 load depth 6");

    // command while busy is ignored (R9)
    do_save(0, 16'd176, 16'h7777, 16'h0001, 16'h0, "R9 save with stray cmd");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_base = 16'd192;
    @(negedge clk);
    cmd_valid = 1'b0;
    drain("R9");
    repeat (4) @(negedge clk);

    // reserved op ignored (R10)
    issue(2'd3, 16'd200);
    chk(busy == 0, "R10", "busy after reserved op", busy, 0);
    repeat (8) @(negedge clk);
    chk(busy == 0 && q.size() == 0, "R10", "still idle", busy, 0);
    chk(brk_byte == 8'hC5 || brk_byte == 8'h00, "R6", "brk held", brk_byte, 8'h00);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule